// File: doc/BRIEF.md
# Bus Machine Cycle Sequencer

This block lays out, clock by clock, the bus machine cycles that one instruction of a small 8-bit processor needs, and it drives the status lines that announce each cycle to the rest of the system. A descriptor arrives together with a start strobe. The descriptor gives the instruction length in bytes, whether the opcode fetch is the long (six-clock) or short (four-clock) kind, and up to two execution cycles that touch memory or I/O. The sequencer issues an opcode fetch first. It then issues one memory read for each remaining instruction byte, and then the requested execution cycles in slot order. Each clock, one T-state is presented.

For every cycle the block gives a cycle-type code, the I/O-versus-memory bit with its output enable, the two status bits, the cycle index and a T-state number that restarts at 1 in each cycle. After the last T-state of the final cycle it pulses done and presents the total T-state count of the instruction. A hold request is honoured only between machine cycles and suspends the instruction. A halt request parks an idle sequencer with the status lines at their halt values.

Top module: `mcyc_sequencer`

## Requirements
- R1: A start strobe is taken only while the block is idle and neither hold nor halt is requested. On the clock after the accepting edge, cycle 0 is shown as an opcode fetch at T-state 1 with busy high.
- R2: The opcode fetch is followed by (length − 1) memory-read cycles. A length field of 0 is treated as 1.
- R3: The execution cycles come after the operand reads. Their count is the count field, limited to 2. Slot 0 is taken from exec_kinds[1:0] and slot 1 from exec_kinds[3:2]. The kind codes are 0 memory write, 1 memory read, 2 I/O read and 3 I/O write.
- R4: The opcode fetch lasts 4 T-states, or 6 when long_fetch is set. Every other cycle lasts 3. tstate counts 1, 2, … up to that length, one per clock.
- R5: cyc_type codes are 0 none, 1 opcode fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write and 6 interrupt acknowledge. While a cycle runs, iom_oe is 1 and (iom, s1, s0) is 011 for fetch, 010 for memory read, 001 for memory write, 110 for I/O read, 101 for I/O write and 111 for interrupt acknowledge. These values stay constant for the whole cycle.
- R6: done is high for exactly the one clock after the last T-state of the final cycle. On that clock total_t equals the sum of all cycle lengths, and the block is idle again.
- R7: A hold request is acted on only at the end of a machine cycle that is not the last one. The block then raises hold_ack with iom_oe, s1 and s0 low and tstate 0, keeps busy high, and after the release resumes with the next cycle at T-state 1. Hold clocks are not added to total_t. When idle, a hold request raises hold_ack at once.
- R8: A halt request while idle sets halted with iom_oe, iom, s1 and s0 all 0. Start has no effect while halted, and dropping the request returns the block to idle.
- R9: Start and descriptor changes while an instruction is in progress do not change its cycle sequence.
- R10: Synchronous active-high reset returns the block to idle. After reset all outputs read 0, including iom_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Descriptor valid / begin instruction |
| instr_len | input | LEN_W (2) | Instruction byte count |
| long_fetch | input | 1 | Select six-clock opcode fetch |
| exec_count | input | XC_W (2) | Number of execution cycles |
| exec_kinds | input | 2*MAX_EXEC (4) | Kind codes of execution slots |
| hold_req | input | 1 | Bus hold request |
| halt_req | input | 1 | Halt request |
| cyc_type | output | 3 | Current cycle type code |
| iom_oe | output | 1 | Output enable for iom |
| iom | output | 1 | I/O (1) or memory (0) cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| tstate | output | T_W (3) | T-state number within the cycle, 0 when none |
| cyc_idx | output | IDX_W (3) | Index of the current machine cycle |
| busy | output | 1 | Instruction in progress, held included |
| hold_ack | output | 1 | Hold granted |
| halted | output | 1 | Halt state |
| done | output | 1 | One-clock end-of-instruction pulse |
| total_t | output | TOT_W (5) | T-state total of the last instruction |

## Verification
The main function is tried with every combination of length field (0 to 3), fetch length, count field (0 to 3) and pairs of execution kinds. This covers one-, two- and three-byte instructions with no, one or two bus accesses, and it shows apart the placement of reads against writes, the slot order, the limit on the count and the length-0 case. About a third of these runs raise hold partway through a cycle. This separates a hold taken at the boundary from one taken early, and shows that hold time is kept out of the total. Every other run keeps start high and scrambles the descriptor after acceptance, which shows whether the descriptor is latched. Separate runs cover hold and halt while idle and a reset in mid-instruction.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [2:0] {
    CT_NONE  = 3'd0,
    CT_FETCH = 3'd1,
    CT_MRD   = 3'd2,
    CT_MWR   = 3'd3,
    CT_IORD  = 3'd4,
    CT_IOWR  = 3'd5,
    CT_INTA  = 3'd6
  } cyc_type_e;

  typedef enum logic [2:0] {
    SQ_IDLE      = 3'd0,
    SQ_RUN       = 3'd1,
    SQ_HOLD_RES  = 3'd2,
    SQ_HOLD_IDLE = 3'd3,
    SQ_HALT      = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic oe;
    logic iom;
    logic s1;
    logic s0;
  } bus_status_t;

  // execution slot kind: 0 mem write, 1 mem read, 2 io read, 3 io write
  function automatic cyc_type_e exec_kind_to_type(input logic [1:0] kind);
    case (kind)
      2'd0:    return CT_MWR;
      2'd1:    return CT_MRD;
      2'd2:    return CT_IORD;
      default: return CT_IOWR;
    endcase
  endfunction

endpackage

// File: rtl/mcyc_cycle_map.sv
module mcyc_cycle_map
  import mcyc_pkg::*;
#(
  parameter int MAX_BYTES = 3,
  parameter int MAX_EXEC  = 2,
  parameter int LEN_W     = 2,
  parameter int IDX_W     = 3
) (
  input  logic [LEN_W-1:0]      len_eff,
  input  logic [2*MAX_EXEC-1:0] exec_kinds,
  input  logic [IDX_W-1:0]      idx,
  output cyc_type_e             ctype
);

  localparam int MAX_CYC = MAX_BYTES + MAX_EXEC;

  cyc_type_e slot_type [MAX_CYC];

  // one type decoder per machine-cycle slot
  for (genvar g = 0; g < MAX_CYC; g++) begin : g_slot
    always_comb begin
      int e;
      e = g - int'(len_eff);
      if (g == 0)
        slot_type[g] = CT_FETCH;
      else if (e < 0)
        slot_type[g] = CT_MRD;
      else if (e < MAX_EXEC)
        slot_type[g] = exec_kind_to_type(exec_kinds[2*e +: 2]);
      else
        slot_type[g] = CT_NONE;
    end
  end

  always_comb begin
    ctype = CT_NONE;
    for (int i = 0; i < MAX_CYC; i++)
      if (idx == IDX_W'(i)) ctype = slot_type[i];
  end

endmodule

// File: rtl/mcyc_status_enc.sv
module mcyc_status_enc
  import mcyc_pkg::*;
(
  input  cyc_type_e   ctype,
  output bus_status_t stat
);

  always_comb begin
    case (ctype)
      CT_FETCH: stat = '{oe: 1'b1, iom: 1'b0, s1: 1'b1, s0: 1'b1};
      CT_MRD:   stat = '{oe: 1'b1, iom: 1'b0, s1: 1'b1, s0: 1'b0};
      CT_MWR:   stat = '{oe: 1'b1, iom: 1'b0, s1: 1'b0, s0: 1'b1};
      CT_IORD:  stat = '{oe: 1'b1, iom: 1'b1, s1: 1'b1, s0: 1'b0};
      CT_IOWR:  stat = '{oe: 1'b1, iom: 1'b1, s1: 1'b0, s0: 1'b1};
      CT_INTA:  stat = '{oe: 1'b1, iom: 1'b1, s1: 1'b1, s0: 1'b1};
      default:  stat = '{oe: 1'b0, iom: 1'b0, s1: 1'b0, s0: 1'b0};
    endcase
  end

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
  import mcyc_pkg::*;
#(
  parameter int MAX_BYTES   = 3,
  parameter int MAX_EXEC    = 2,
  parameter int FETCH_SHORT = 4,
  parameter int FETCH_LONG  = 6,
  parameter int BUS_T       = 3,
  parameter int LEN_W       = $clog2(MAX_BYTES + 1),
  parameter int XC_W        = $clog2(MAX_EXEC + 1),
  parameter int IDX_W       = $clog2(MAX_BYTES + MAX_EXEC),
  parameter int T_W         = $clog2(FETCH_LONG + 1),
  parameter int TOT_W       = $clog2((MAX_BYTES + MAX_EXEC) * FETCH_LONG + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [LEN_W-1:0]      instr_len,
  input  logic                  long_fetch,
  input  logic [XC_W-1:0]       exec_count,
  input  logic [2*MAX_EXEC-1:0] exec_kinds,
  input  logic                  hold_req,
  input  logic                  halt_req,
  output logic [2:0]            cyc_type,
  output logic                  iom_oe,
  output logic                  iom,
  output logic                  s1,
  output logic                  s0,
  output logic [T_W-1:0]        tstate,
  output logic [IDX_W-1:0]      cyc_idx,
  output logic                  busy,
  output logic                  hold_ack,
  output logic                  halted,
  output logic                  done,
  output logic [TOT_W-1:0]      total_t
);

  // ---------------- state ----------------
  seq_state_e            st_q, st_n;
  logic [IDX_W-1:0]      idx_q, idx_n;
  logic [T_W-1:0]        tcnt_q, tcnt_n;
  logic [TOT_W-1:0]      tot_q, tot_n;
  logic [TOT_W-1:0]      total_q, total_n;
  logic                  done_q, done_n;
  logic [LEN_W-1:0]      len_q, len_n;
  logic                  lf_q, lf_n;
  logic [2*MAX_EXEC-1:0] kinds_q, kinds_n;
  logic [IDX_W-1:0]      ncyc_q, ncyc_n;
  cyc_type_e             ctype_q;
  bus_status_t           stat_q;

  // ---------------- incoming descriptor ----------------
  logic [LEN_W-1:0] len_in_eff;
  logic [XC_W-1:0]  xc_in_eff;
  logic [IDX_W-1:0] ncyc_in;
  logic             accept;

  assign len_in_eff = (instr_len == '0) ? LEN_W'(1) : instr_len;
  assign xc_in_eff  = (exec_count > XC_W'(MAX_EXEC)) ? XC_W'(MAX_EXEC) : exec_count;
  assign ncyc_in    = IDX_W'(len_in_eff) + IDX_W'(xc_in_eff);
  assign accept     = (st_q == SQ_IDLE) && !hold_req && !halt_req && start;

  // ---------------- cycle maps ----------------
  cyc_type_e cur_type, nxt_type, nxt_type_gated;
  logic [T_W-1:0] cur_len;
  logic           cur_last_t, cur_final;

  mcyc_cycle_map #(
    .MAX_BYTES(MAX_BYTES), .MAX_EXEC(MAX_EXEC), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_map_cur (
    .len_eff   (len_q),
    .exec_kinds(kinds_q),
    .idx       (idx_q),
    .ctype     (cur_type)
  );

  mcyc_cycle_map #(
    .MAX_BYTES(MAX_BYTES), .MAX_EXEC(MAX_EXEC), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_map_nxt (
    .len_eff   (len_n),
    .exec_kinds(kinds_n),
    .idx       (idx_n),
    .ctype     (nxt_type)
  );

  assign cur_len    = (cur_type == CT_FETCH) ? (lf_q ? T_W'(FETCH_LONG) : T_W'(FETCH_SHORT))
                                             : T_W'(BUS_T);
  assign cur_last_t = (tcnt_q == cur_len);
  assign cur_final  = (idx_q == ncyc_q - IDX_W'(1));

  // ---------------- next-state ----------------
  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    tcnt_n  = tcnt_q;
    tot_n   = tot_q;
    total_n = total_q;
    done_n  = 1'b0;
    len_n   = len_q;
    lf_n    = lf_q;
    kinds_n = kinds_q;
    ncyc_n  = ncyc_q;
    case (st_q)
      SQ_IDLE: begin
        if (hold_req)      st_n = SQ_HOLD_IDLE;
        else if (halt_req) st_n = SQ_HALT;
        else if (accept) begin
          st_n    = SQ_RUN;
          idx_n   = '0;
          tcnt_n  = T_W'(1);
          tot_n   = TOT_W'(1);
          len_n   = len_in_eff;
          lf_n    = long_fetch;
          kinds_n = exec_kinds;
          ncyc_n  = ncyc_in;
        end
      end
      SQ_RUN: begin
        if (!cur_last_t) begin
          tcnt_n = tcnt_q + T_W'(1);
          tot_n  = tot_q + TOT_W'(1);
        end else if (cur_final) begin
          st_n    = SQ_IDLE;
          tcnt_n  = '0;
          idx_n   = '0;
          done_n  = 1'b1;
          total_n = tot_q;
        end else if (hold_req) begin
          st_n   = SQ_HOLD_RES;
          idx_n  = idx_q + IDX_W'(1);
          tcnt_n = '0;
        end else begin
          idx_n  = idx_q + IDX_W'(1);
          tcnt_n = T_W'(1);
          tot_n  = tot_q + TOT_W'(1);
        end
      end
      SQ_HOLD_RES: begin
        if (!hold_req) begin
          st_n   = SQ_RUN;
          tcnt_n = T_W'(1);
          tot_n  = tot_q + TOT_W'(1);
        end
      end
      SQ_HOLD_IDLE: if (!hold_req) st_n = SQ_IDLE;
      SQ_HALT:      if (!halt_req) st_n = SQ_IDLE;
      default:      st_n = SQ_IDLE;
    endcase
  end

  assign nxt_type_gated = (st_n == SQ_RUN) ? nxt_type : CT_NONE;

  bus_status_t nxt_stat;
  mcyc_status_enc u_enc (
    .ctype(nxt_type_gated),
    .stat (nxt_stat)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      tcnt_q  <= '0;
      tot_q   <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
      len_q   <= LEN_W'(1);
      lf_q    <= 1'b0;
      kinds_q <= '0;
      ncyc_q  <= IDX_W'(1);
      ctype_q <= CT_NONE;
      stat_q  <= '0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      tcnt_q  <= tcnt_n;
      tot_q   <= tot_n;
      total_q <= total_n;
      done_q  <= done_n;
      len_q   <= len_n;
      lf_q    <= lf_n;
      kinds_q <= kinds_n;
      ncyc_q  <= ncyc_n;
      ctype_q <= nxt_type_gated;
      stat_q  <= nxt_stat;
    end
  end

  assign cyc_type = ctype_q;
  assign iom_oe   = stat_q.oe;
  assign iom      = stat_q.iom;
  assign s1       = stat_q.s1;
  assign s0       = stat_q.s0;
  assign tstate   = tcnt_q;
  assign cyc_idx  = (st_q == SQ_IDLE) ? '0 : idx_q;
  assign busy     = (st_q == SQ_RUN) || (st_q == SQ_HOLD_RES);
  assign hold_ack = (st_q == SQ_HOLD_RES) || (st_q == SQ_HOLD_IDLE);
  assign halted   = (st_q == SQ_HALT);
  assign done     = done_q;
  assign total_t  = total_q;

  // ---------------- assertions ----------------
  p_fetch_first_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN && idx_q == '0) |-> (cyc_type == CT_FETCH));

  p_tstate_step_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN && tcnt_q != T_W'(1)) |-> (tcnt_q == $past(tcnt_q) + T_W'(1)));

  p_tstate_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN) |-> (tcnt_q >= T_W'(1) &&
      tcnt_q <= ((cyc_type == CT_FETCH) ? T_W'(FETCH_LONG) : T_W'(BUS_T))));

  p_status_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN && tcnt_q != T_W'(1)) |-> ($stable(stat_q) && $stable(cyc_type)));

  p_oe_running_r5: assert property (@(posedge clk) disable iff (rst)
    iom_oe |-> (st_q == SQ_RUN));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_q == SQ_IDLE && $past(st_q) == SQ_RUN));

  p_hold_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HOLD_RES && $past(st_q) == SQ_RUN) |-> ($past(tcnt_q) == $past(cur_len)));

  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!iom_oe && !s1 && !s0));

  p_halt_status_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!iom_oe && !iom && !s1 && !s0 && !busy));

  p_desc_latched_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN && $past(st_q) == SQ_RUN) |-> ($stable(len_q) && $stable(kinds_q) && $stable(ncyc_q)));

endmodule

// File: tb/test_mcyc_sequencer.sv
module test_mcyc_sequencer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [1:0] instr_len;
  logic       long_fetch;
  logic [1:0] exec_count;
  logic [3:0] exec_kinds;
  logic       hold_req;
  logic       halt_req;
  logic [2:0] cyc_type;
  logic       iom_oe, iom, s1, s0;
  logic [2:0] tstate;
  logic [2:0] cyc_idx;
  logic       busy, hold_ack, halted, done;
  logic [4:0] total_t;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_sequencer i_mcyc_sequencer (
    .clk(clk), .rst(rst), .start(start), .instr_len(instr_len),
    .long_fetch(long_fetch), .exec_count(exec_count), .exec_kinds(exec_kinds),
    .hold_req(hold_req), .halt_req(halt_req), .cyc_type(cyc_type),
    .iom_oe(iom_oe), .iom(iom), .s1(s1), .s0(s0), .tstate(tstate),
    .cyc_idx(cyc_idx), .busy(busy), .hold_ack(hold_ack), .halted(halted),
    .done(done), .total_t(total_t)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // R5 code table
  function automatic int exp_kind_type(input int k);
    case (k)
      0: return 3;
      1: return 2;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_stat(input int t);
    case (t)
      1: return 4'b1011;
      2: return 4'b1010;
      3: return 4'b1001;
      4: return 4'b1110;
      5: return 4'b1101;
      6: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk_quiet(input string req);
    chk(req, "iom_oe/iom/s1/s0", int'({iom_oe, iom, s1, s0}), 0);
    chk(req, "tstate", int'(tstate), 0);
    chk(req, "cyc_type", int'(cyc_type), 0);
  endtask

  task automatic run_instr(input int ln, input int lf, input int xc,
                           input int k0, input int k1, input int hs, input bit keep_start);
    int leff, xe, nc, tot;
    leff = (ln == 0) ? 1 : ln;
    xe   = (xc > 2) ? 2 : xc;
    nc   = leff + xe;
    tot  = 0;
    start = 1'b1; instr_len = 2'(ln); long_fetch = lf[0];
    exec_count = 2'(xc); exec_kinds = {k1[1:0], k0[1:0]};
    @(negedge clk);
    start = keep_start;
    instr_len = ~instr_len; long_fetch = ~long_fetch;      // R9 scramble
    exec_count = ~exec_count; exec_kinds = ~exec_kinds;
    for (int s = 0; s < nc; s++) begin
      int et, el;
      if (s == 0) et = 1;
      else if (s < leff) et = 2;
      else et = exp_kind_type((s - leff == 0) ? k0 : k1);
      el = (s == 0) ? ((lf != 0) ? 6 : 4) : 3;
      for (int t = 1; t <= el; t++) begin
        chk((s == 0) ? "R1" : ((s < leff) ? "R2" : "R3"), "cyc_type", int'(cyc_type), et);
        chk("R5", "iom_oe/iom/s1/s0", int'({iom_oe, iom, s1, s0}), exp_stat(et));
        chk("R4", "tstate", int'(tstate), t);
        chk("R9", "cyc_idx", int'(cyc_idx), s);
        chk("R1", "busy", int'(busy), 1);
        tot++;
        if (s == hs && t == 1) hold_req = 1'b1;
        if (s == nc - 1 && t == el) start = 1'b0;
        @(negedge clk);
      end
      if (s == hs) begin
        for (int h = 1; h <= 3; h++) begin
          chk("R7", "hold_ack", int'(hold_ack), 1);
          chk("R7", "busy in hold", int'(busy), 1);
          chk_quiet("R7");
          if (h == 3) hold_req = 1'b0;
          @(negedge clk);
        end
      end
    end
    chk("R6", "done", int'(done), 1);
    chk("R6", "total_t", int'(total_t), tot);
    chk("R6", "busy after end", int'(busy), 0);
    chk("R6", "iom_oe after end", int'(iom_oe), 0);
    @(negedge clk);
    chk("R6", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int combo;
    rst = 1'b1; start = 1'b0; instr_len = '0; long_fetch = 1'b0;
    exec_count = '0; exec_kinds = '0; hold_req = 1'b0; halt_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk_quiet("R10");
    chk("R10", "busy/hold_ack/halted/done", int'({busy, hold_ack, halted, done}), 0);
    chk("R10", "total_t", int'(total_t), 0);
    @(negedge clk);

    // sweep R1..R7, R9
    combo = 0;
    for (int ln = 0; ln < 4; ln++)
      for (int lf = 0; lf < 2; lf++)
        for (int xc = 0; xc < 4; xc++)
          for (int k0 = 0; k0 < 4; k0++)
            for (int k1 = 0; k1 < 4; k1++) begin
              int leff, nc, hs;
              leff = (ln == 0) ? 1 : ln;
              nc   = leff + ((xc > 2) ? 2 : xc);
              hs   = ((combo % 3) == 0 && nc > 1) ? (combo % (nc - 1)) : -1;
              run_instr(ln, lf, xc, k0, k1, hs, combo[0]);
              combo++;
            end

    // R7 hold while idle, start ignored
    hold_req = 1'b1; start = 1'b1; instr_len = 2'd1;
    @(negedge clk);
    chk("R7", "idle hold_ack", int'(hold_ack), 1);
    chk("R7", "idle hold busy", int'(busy), 0);
    chk_quiet("R7");
    @(negedge clk);
    chk("R7", "idle hold keeps busy low", int'(busy), 0);
    start = 1'b0; hold_req = 1'b0;
    @(negedge clk);
    chk("R7", "hold released", int'(hold_ack), 0);

    // R8 halt while idle
    halt_req = 1'b1;
    @(negedge clk);
    chk("R8", "halted", int'(halted), 1);
    chk("R8", "iom_oe/iom/s1/s0", int'({iom_oe, iom, s1, s0}), 0);
    start = 1'b1;
    @(negedge clk);
    chk("R8", "start while halted busy", int'(busy), 0);
    chk("R8", "start while halted tstate", int'(tstate), 0);
    start = 1'b0; halt_req = 1'b0;
    @(negedge clk);
    chk("R8", "halt released", int'(halted), 0);

    // R10 reset in mid-instruction
    start = 1'b1; instr_len = 2'd3; long_fetch = 1'b1; exec_count = 2'd2;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_quiet("R10");
    chk("R10", "busy after reset", int'(busy), 0);
    @(negedge clk);
    chk("R10", "no resume after reset", int'(busy), 0);

    // R1 back to normal: 1-byte internal op totals 4
    run_instr(1, 0, 0, 0, 0, -1, 1'b0);

    summary();
    $finish;
  end

endmodule